// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire bus slave that owns a byte-wide memory array held in on-chip registers. A fast system clock oversamples the bus clock and data lines. From those samples the block finds Start and Stop conditions and shifts in bytes. It answers a select byte that carries a fixed family code and three strap bits taken from `dev_sel_i`. The bus data line is open-drain: the block only ever pulls it low, through `sda_oe`.

A master sets a word address with two bytes and then writes one or more data bytes. The data bytes collect in a 32-byte page latch, and the array is updated only after the closing Stop. A self-timed programming interval follows. It runs for a parameterised number of clock cycles, and during it the block stays silent on the bus. Reads come in three forms: from the current address, from an address set by a dummy write followed by a repeated Start, and as sequential streams that continue until the master withholds its acknowledge.

The array holds 2^`WORD_AW` bytes. The full-size configuration uses `WORD_AW` = 13, which gives 8192 bytes. The default is smaller so that the register array stays light. A write-protect input is checked at the Stop that closes a write.

Top module: `eeprom_2wire_slave`

## Requirements
- R1: After reset, and while no transfer is in progress, `sda_oe` is 0 and the data line is released.
- R2: The select byte is read most significant bit first. It is the code 1010, then three strap bits that must equal `dev_sel_i[2:0]`, then a direction bit (0 = write, 1 = read). On a match the block pulls SDA low for the whole ninth clock pulse. On any mismatch it does not drive SDA for the rest of the transfer.
- R3: A write carries a high address byte and then a low address byte. The word address is the low `WORD_AW` bits of the two bytes taken together, so the upper bits of the high byte are ignored. A single data byte followed by Stop is stored at that address.
- R4: During a write, each data byte advances only the low 5 address bits. A page write that starts near the end of a 32-byte page therefore wraps to the start of the same page.
- R5: When more than 32 data bytes arrive before Stop, only the last 32 are stored, and each later byte replaces the one 32 positions before it.
- R6: A Stop that closes a write with at least one data byte starts a programming interval of `PROG_CYCLES` clock cycles. During that interval every select byte, including a matching one, receives no acknowledge.
- R7: If `wp_i` is 1 at the closing Stop, the data bytes have still been acknowledged, but no programming interval starts and the array is left unchanged.
- R8: A write of an address followed by a repeated Start and a read-direction select byte returns the byte stored at that address.
- R9: A sequential read advances the full word address after each byte and wraps from the last location to address 0.
- R10: A read that starts directly with a read-direction select byte continues from the location after the last byte read.
- R11: When the master does not acknowledge a read byte, the block releases SDA and does not drive it again until the next Start.
- R12: The block changes `sda_oe` only while SCL is low. A Stop always returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line sample |
| sda_i | input | 1 | Bus data line sample |
| sda_oe | output | 1 | 1 pulls the bus data line low |
| dev_sel_i | input | 3 | Strap bits matched against the select byte |
| wp_i | input | 1 | Write protect, 1 blocks array updates |

## Verification
On every cycle the assertions check several conditions. The data line driver moves only while the synchronised SCL is low. The driver is off while idle and during programming, so no acknowledge can escape while the block is busy. A programming interval never starts from a protected Stop and never restarts while one is running. A Stop always lands the controller in idle. Only the bench scenarios can show what ends up in the array: where page writes wrap, which 32 bytes survive an overlong write, that write-protected data never appears, and how the address pointer carries over between random, sequential and current-address reads, including the wrap from the top of the array to address 0.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_TXACK,
      ST_WAIT
   } ee2w_state_t;

   typedef enum logic [1:0] {
      K_DEV,
      K_AHI,
      K_ALO,
      K_DATA
   } ee2w_kind_t;

   localparam logic [3:0] EE2W_FAMILY = 4'b1010;

endpackage

// File: rtl/ee2w_line_sampler.sv
module ee2w_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
   logic                   scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_sync <= '1;
         sda_sync <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
         sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
         scl_q    <= scl_s;
         sda_q    <= sda_s;
      end
   end

   assign scl_s     = scl_sync[SYNC_STAGES-1];
   assign sda_s     = sda_sync[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ee2w_page_latch.sv
module ee2w_page_latch #(
   parameter int PAGE_BYTES = 32,
   parameter int DATA_W     = 8,
   localparam int COL_W     = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [COL_W-1:0]  wr_col,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [COL_W-1:0]  rd_col,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   generate
      if ((1 << COL_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
   endgenerate

   logic [DATA_W-1:0]     slot  [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         valid <= '0;
      end else if (wr_en) begin
         valid[wr_col] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) slot[wr_col] <= wr_data;
   end

   assign rd_data  = slot[rd_col];
   assign rd_valid = valid[rd_col];

endmodule

// File: rtl/ee2w_prog_timer.sv
module ee2w_prog_timer #(
   parameter int CYCLES = 1000,
   parameter int STEPS  = 32,
   localparam int CW    = $clog2(CYCLES + 1),
   localparam int SW    = $clog2(STEPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          step_en,
   output logic [SW-1:0] step_idx
);

   generate
      if (CYCLES < STEPS) begin : g_bad_cycles
         $error("CYCLES must cover one step per page byte");
      end
   endgenerate

   localparam logic [CW-1:0] LAST    = CW'(CYCLES - 1);
   localparam logic [CW-1:0] STEPS_C = CW'(STEPS);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == LAST) busy <= 1'b0;
         cnt <= cnt + 1'b1;
      end
   end

   assign step_en  = busy && (cnt < STEPS_C);
   assign step_idx = cnt[SW-1:0];

   a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/eeprom_2wire_slave.sv
module eeprom_2wire_slave
   import ee2w_pkg::*;
#(
   parameter int WORD_AW     = 11,
   parameter int PAGE_BYTES  = 32,
   parameter int PROG_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] dev_sel_i,
   input  logic       wp_i
);

   localparam int DEPTH = 1 << WORD_AW;
   localparam int COL_W = $clog2(PAGE_BYTES);
   localparam logic [WORD_AW-1:0] PTR_ONE = WORD_AW'(1);
   localparam logic [COL_W-1:0]   COL_ONE = COL_W'(1);

   generate
      if (WORD_AW > 13 || WORD_AW <= COL_W) begin : g_bad_aw
         $error("WORD_AW must lie above the page column width and at most 13");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   ee2w_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   ee2w_state_t        state;
   ee2w_kind_t         kind;
   logic [3:0]         bitcnt;
   logic [7:0]         shreg, addr_hi, tx_sh;
   logic [WORD_AW-1:0] ptr;
   logic               rw_rd, wr_pending, master_ack;

   logic               busy, step_en;
   logic [COL_W-1:0]   step_idx;
   logic [7:0]         lat_data;
   logic               lat_valid;
   logic [7:0]         mem [DEPTH];

   logic        byte_done, dev_match, prog_start, lat_wr, lat_clr;
   logic [15:0] full_addr;
   logic [7:0]  mem_rd;

   assign byte_done  = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
   assign dev_match  = (shreg[7:4] == EE2W_FAMILY) && (shreg[3:1] == dev_sel_i) && !busy;
   assign prog_start = stop_det && wr_pending && !wp_i && !busy;
   assign lat_wr     = byte_done && (kind == K_DATA);
   assign lat_clr    = (byte_done && (kind == K_ALO)) || (stop_det && wr_pending && wp_i);
   assign full_addr  = {addr_hi, shreg};
   assign mem_rd     = mem[ptr];

   ee2w_page_latch #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(8)) u_latch (
      .clk(clk), .rst_n(rst_n), .clr(lat_clr), .wr_en(lat_wr),
      .wr_col(ptr[COL_W-1:0]), .wr_data(shreg), .rd_col(step_idx),
      .rd_data(lat_data), .rd_valid(lat_valid)
   );

   ee2w_prog_timer #(.CYCLES(PROG_CYCLES), .STEPS(PAGE_BYTES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(prog_start),
      .busy(busy), .step_en(step_en), .step_idx(step_idx)
   );

   // programming walks the page one column per cycle
   always_ff @(posedge clk) begin
      if (step_en && lat_valid) mem[{ptr[WORD_AW-1:COL_W], step_idx}] <= lat_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         kind       <= K_DEV;
         bitcnt     <= '0;
         shreg      <= '0;
         addr_hi    <= '0;
         tx_sh      <= '0;
         ptr        <= '0;
         rw_rd      <= 1'b0;
         wr_pending <= 1'b0;
         master_ack <= 1'b0;
         sda_oe     <= 1'b0;
      end else if (start_det) begin
         state      <= ST_RX;
         kind       <= K_DEV;
         bitcnt     <= '0;
         wr_pending <= 1'b0;
         sda_oe     <= 1'b0;
      end else if (stop_det) begin
         state      <= ST_IDLE;
         wr_pending <= 1'b0;
         sda_oe     <= 1'b0;
      end else begin
         unique case (state)
            ST_RX: begin
               if (scl_rise && bitcnt != 4'd8) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end
               if (byte_done) begin
                  bitcnt <= '0;
                  state  <= ST_ACK;
                  sda_oe <= 1'b1;
                  unique case (kind)
                     K_DEV: begin
                        rw_rd <= shreg[0];
                        if (!dev_match) begin
                           state  <= ST_WAIT;
                           sda_oe <= 1'b0;
                        end
                     end
                     K_AHI:  addr_hi <= shreg;
                     K_ALO:  ptr     <= full_addr[WORD_AW-1:0];
                     K_DATA: begin
                        ptr        <= {ptr[WORD_AW-1:COL_W], ptr[COL_W-1:0] + COL_ONE};
                        wr_pending <= 1'b1;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  if (kind == K_DEV && rw_rd) begin
                     tx_sh  <= mem_rd;
                     ptr    <= ptr + PTR_ONE;
                     sda_oe <= ~mem_rd[7];
                     state  <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_RX;
                     kind   <= (kind == K_DEV) ? K_AHI :
                               (kind == K_AHI) ? K_ALO : K_DATA;
                  end
               end
            end
            ST_TX: begin
               if (scl_rise) bitcnt <= bitcnt + 4'd1;
               if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     sda_oe <= 1'b0;
                     state  <= ST_TXACK;
                  end else begin
                     tx_sh  <= {tx_sh[6:0], 1'b0};
                     sda_oe <= ~tx_sh[6];
                  end
               end
            end
            ST_TXACK: begin
               if (scl_rise) master_ack <= ~sda_s;
               if (scl_fall) begin
                  if (master_ack) begin
                     tx_sh  <= mem_rd;
                     ptr    <= ptr + PTR_ONE;
                     sda_oe <= ~mem_rd[7];
                     state  <= ST_TX;
                  end else begin
                     state  <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   a_r12_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   a_r12_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE));

   a_r6_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   a_r7_wp_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(wp_i));

endmodule

// File: tb/eeprom_2wire_slave_bench.sv
module eeprom_2wire_slave_bench;

   localparam int H    = 8;
   localparam int PROG = 400;
   localparam logic [2:0] STRAP = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic wp = 1'b0;
   logic sda_oe;
   logic sda_line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] wbuf [64];
   logic [7:0] rbuf [64];

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   eeprom_2wire_slave #(.WORD_AW(11), .PAGE_BYTES(32), .PROG_CYCLES(PROG), .SYNC_STAGES(2))
   u_eeprom_2wire_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .dev_sel_i(STRAP), .wp_i(wp)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hp();
      repeat (H) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hp();
      scl_m = 1'b1; hp();
      sda_m = 1'b0; hp();
      scl_m = 1'b0; hp();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hp();
      scl_m = 1'b1; hp();
      sda_m = 1'b1; hp();
   endtask

   task automatic put_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hp();
         scl_m = 1'b1; hp();
         scl_m = 1'b0;
      end
      sda_m = 1'b1; hp();
      scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      ack = (sda_line == 1'b0);
      repeat (H/2) @(negedge clk);
      scl_m = 1'b0;
   endtask

   task automatic get_byte(output logic [7:0] b, input bit mack);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hp();
         scl_m = 1'b1;
         repeat (H/2) @(negedge clk);
         b[i] = sda_line;
         repeat (H/2) @(negedge clk);
         scl_m = 1'b0;
      end
      sda_m = ~mack; hp();
      scl_m = 1'b1; hp();
      scl_m = 1'b0;
      sda_m = 1'b1;
   endtask

   function automatic logic [7:0] dev(input logic [2:0] s, input bit rd);
      return {4'b1010, s, rd};
   endfunction

   // write n bytes of wbuf at address {hi,lo}, no stop
   task automatic wr_block(input logic [7:0] hi, input logic [7:0] lo, input int n, input string tag);
      bit a;
      bus_start();
      put_byte(dev(STRAP, 1'b0), a); check(a, tag, a, 1);
      put_byte(hi, a);               check(a, tag, a, 1);
      put_byte(lo, a);               check(a, tag, a, 1);
      for (int i = 0; i < n; i++) begin
         put_byte(wbuf[i], a);
         check(a, tag, a, 1);
      end
   endtask

   task automatic rd_block(input logic [7:0] hi, input logic [7:0] lo, input int n, input string tag);
      bit a;
      bus_start();
      put_byte(dev(STRAP, 1'b0), a); check(a, tag, a, 1);
      put_byte(hi, a);               check(a, tag, a, 1);
      put_byte(lo, a);               check(a, tag, a, 1);
      bus_start();
      put_byte(dev(STRAP, 1'b1), a); check(a, tag, a, 1);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         get_byte(b, i != n - 1);
         rbuf[i] = b;
      end
      repeat (4) @(negedge clk);
      check(sda_oe == 1'b0, "R11 released after nack", sda_oe, 0);
      bus_stop();
   endtask

   task automatic wait_prog();
      repeat (PROG + 100) @(negedge clk);
   endtask

   initial begin
      bit a;
      logic [7:0] b;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(sda_oe == 1'b0, "R1 reset idle", sda_oe, 0);

      // R2 select decoding
      bus_start(); put_byte(dev(3'b100, 1'b0), a); bus_stop();
      check(!a, "R2 wrong strap", a, 0);
      bus_start(); put_byte({4'b1011, STRAP, 1'b0}, a); bus_stop();
      check(!a, "R2 wrong family", a, 0);
      bus_start(); put_byte(dev(STRAP, 1'b0), a); bus_stop();
      check(a, "R2 matching select", a, 1);
      check(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);

      // R3 byte write, high bits ignored; R6 busy
      wbuf[0] = 8'h5A;
      wr_block(8'hF9, 8'h23, 1, "R3 byte write ack");
      bus_stop();
      bus_start(); put_byte(dev(STRAP, 1'b0), a); bus_stop();
      check(!a, "R6 select during programming", a, 0);
      wait_prog();
      bus_start(); put_byte(dev(STRAP, 1'b0), a); bus_stop();
      check(a, "R6 select after programming", a, 1);
      rd_block(8'h01, 8'h23, 1, "R8 random read");
      check(rbuf[0] == 8'h5A, "R3 R8 byte readback", rbuf[0], 8'h5A);

      // R4 page wrap from column 28
      for (int i = 0; i < 8; i++) wbuf[i] = 8'hA0 + 8'(i);
      wr_block(8'h02, 8'h1C, 8, "R4 page write ack");
      bus_stop(); wait_prog();
      rd_block(8'h02, 8'h1C, 4, "R4 read tail");
      for (int i = 0; i < 4; i++)
         check(rbuf[i] == 8'hA0 + 8'(i), "R4 page tail", rbuf[i], 8'hA0 + i);
      rd_block(8'h02, 8'h00, 4, "R4 read head");
      for (int i = 0; i < 4; i++)
         check(rbuf[i] == 8'hA4 + 8'(i), "R4 wrapped head", rbuf[i], 8'hA4 + i);

      // R5 forty bytes into one page
      for (int i = 0; i < 40; i++) wbuf[i] = 8'h40 + 8'(i);
      wr_block(8'h03, 8'h00, 40, "R5 overlong write ack");
      bus_stop(); wait_prog();
      rd_block(8'h03, 8'h00, 32, "R5 read page");
      for (int c = 0; c < 32; c++) begin
         int k;
         k = (c < 8) ? c + 32 : c;
         check(rbuf[c] == 8'(8'h40 + k), "R5 last 32 kept", rbuf[c], 8'h40 + k);
      end

      // R7 write protect
      wp = 1'b1;
      wbuf[0] = 8'hA5;
      wr_block(8'h01, 8'h23, 1, "R7 protected data ack");
      bus_stop();
      bus_start(); put_byte(dev(STRAP, 1'b0), a); bus_stop();
      check(a, "R7 no programming started", a, 1);
      wp = 1'b0;
      rd_block(8'h01, 8'h23, 1, "R7 read");
      check(rbuf[0] == 8'h5A, "R7 array unchanged", rbuf[0], 8'h5A);

      // R9 sequential wrap from top to 0
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      wr_block(8'h07, 8'hFE, 2, "R9 top write");
      bus_stop(); wait_prog();
      wbuf[0] = 8'h33;
      wr_block(8'h00, 8'h00, 1, "R9 zero write");
      bus_stop(); wait_prog();
      rd_block(8'h07, 8'hFE, 3, "R9 read");
      check(rbuf[0] == 8'h11, "R9 seq byte0", rbuf[0], 8'h11);
      check(rbuf[1] == 8'h22, "R9 seq byte1", rbuf[1], 8'h22);
      check(rbuf[2] == 8'h33, "R9 wrap to zero", rbuf[2], 8'h33);

      // R10 current address read
      rd_block(8'h03, 8'h00, 1, "R10 set pointer");
      bus_start(); put_byte(dev(STRAP, 1'b1), a);
      check(a, "R10 read select", a, 1);
      get_byte(b, 1'b0);
      repeat (4) @(negedge clk);
      check(sda_oe == 1'b0, "R11 released", sda_oe, 0);
      bus_stop();
      check(b == 8'h61, "R10 current address", b, 8'h61);
      check(sda_oe == 1'b0, "R1 idle at end", sda_oe, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule